// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps each virtual address issued by a processor onto a physical address by way of a small table of segment descriptors held per process. The top bits of the virtual address pick one descriptor. The remaining bits are an offset into that segment. A descriptor holds a base address, a limit and a set of permission bits. Every request carries an access kind: read, write or instruction fetch. The block checks the offset against the limit and the access kind against the permission bits. It then returns either the base plus the offset, or a fault code that says which check failed.

Privileged software fills the table through a descriptor write port. A write made while the privilege input is low has no effect. A combinational read-back port gives software the contents of any entry, so the whole table can be saved on a context switch and written back later. Translation is combinational and ends in one register stage. A new request can therefore be accepted on every clock cycle, and each answer appears in the cycle after its request.

Top module: `seg_xlate`

## Requirements
- R1: While `rst_n` is low at a clock edge, every descriptor is cleared to base 0, limit 0 and no permissions, and the response outputs are all zero.
- R2: The segment number is `req_vaddr[31:28]` and the offset is `req_vaddr[27:0]`.
- R3: An offset strictly greater than the selected segment's limit gives fault code 2'b01 (bounds) and a physical address of 0. An offset equal to the limit is legal.
- R4: When both checks pass, the response has fault code 2'b00 and the physical address is base plus the zero-extended offset, taken modulo 2^32.
- R5: Access codes are 2'b00 read, 2'b01 write, 2'b10 fetch and 2'b11 reserved. Permission bit 0 allows read, bit 1 allows write and bit 2 allows fetch. An access whose bit is clear, or any reserved access, gives fault code 2'b10 (permission) and address 0.
- R6: When the bounds check and the permission check both fail, the bounds code 2'b01 is reported.
- R7: `rsp_valid` is `req_valid` delayed by one cycle. In a cycle with no response, the fault code and the address are 0.
- R8: A write with `wr_en` and `wr_priv` both high replaces the entry at `wr_idx`. A request in the same cycle still sees the old entry. Requests from the next cycle on see the new one.
- R9: A write with `wr_en` high and `wr_priv` low changes no entry.
- R10: `rd_base`, `rd_limit` and `rd_perm` show the entry selected by `rd_idx` in the same cycle, without waiting for a clock edge.
- R11: Requests presented on back-to-back cycles are each answered, in order, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind (read, write, fetch, reserved) |
| wr_en | input | 1 | Descriptor write strobe |
| wr_priv | input | 1 | Writer is privileged |
| wr_idx | input | 4 | Descriptor index to write |
| wr_base | input | 32 | New base address |
| wr_limit | input | 28 | New limit (highest legal offset) |
| wr_perm | input | 3 | New permission bits {fetch, write, read} |
| rd_idx | input | 4 | Descriptor index to read back |
| rd_base | output | 32 | Base of the entry being read back |
| rd_limit | output | 28 | Limit of the entry being read back |
| rd_perm | output | 3 | Permissions of the entry being read back |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address, or 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 bounds, 10 permission |

## Verification
The main function is exercised with several kinds of offset. Offsets exactly at a segment's limit and one past it show whether the bounds test is "greater than" or "greater or equal". Offsets that are legal only for some access kinds separate the permission check from the bounds check. Requests that break both rules confirm that the bounds fault takes priority. A base near the top of the address space shows that the sum wraps. A long run of back-to-back random requests, mixed with privileged and unprivileged writes, exposes mistakes in when a new entry takes effect and in the index used for an entry.

// File: rtl/seg_xlate_pkg.sv
// Package: shared codes for the segment translator.
// Assumes access kind and fault code both fit in two bits.
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_BOUNDS = 2'b01,
        FLT_PERM   = 2'b10
    } fault_t;

    localparam int PERM_W   = 3;
    localparam int PERM_RD  = 0;
    localparam int PERM_WR  = 1;
    localparam int PERM_EX  = 2;

endpackage

// File: rtl/seg_desc_table.sv
// Module: descriptor register file.
// Holds one base/limit/permission entry per segment. It has one write port,
// gated by privilege, and two combinational read ports: one for lookup and
// one for read-back. Assumes synchronous active-low reset.
module seg_desc_table #(
    parameter int SEG_W  = 4,
    parameter int BASE_W = 32,
    parameter int LIM_W  = 28,
    parameter int PERM_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_priv,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [SEG_W-1:0]  lk_idx,
    output logic [BASE_W-1:0] lk_base,
    output logic [LIM_W-1:0]  lk_limit,
    output logic [PERM_W-1:0] lk_perm,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic [PERM_W-1:0] rd_perm
);
    localparam int NSEG = 1 << SEG_W;

    logic [BASE_W-1:0] tbl_base  [NSEG];
    logic [LIM_W-1:0]  tbl_limit [NSEG];
    logic [PERM_W-1:0] tbl_perm  [NSEG];
    logic              wr_ok;

    // Accept a write only from privileged software.
    assign wr_ok = wr_en && wr_priv;

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        // Per-entry storage: clear on reset, load on a matching privileged write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_base[g]  <= '0;
                tbl_limit[g] <= '0;
                tbl_perm[g]  <= '0;
            end else if (wr_ok && (wr_idx == SEG_W'(g))) begin
                tbl_base[g]  <= wr_base;
                tbl_limit[g] <= wr_limit;
                tbl_perm[g]  <= wr_perm;
            end
        end
    end

    // Lookup port feeding the checker.
    assign lk_base  = tbl_base[lk_idx];
    assign lk_limit = tbl_limit[lk_idx];
    assign lk_perm  = tbl_perm[lk_idx];

    // Read-back port used to save the table.
    assign rd_base  = tbl_base[rd_idx];
    assign rd_limit = tbl_limit[rd_idx];
    assign rd_perm  = tbl_perm[rd_idx];

    // R8
    priv_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_priv |=> tbl_base[$past(wr_idx)] == $past(wr_base)
                          && tbl_limit[$past(wr_idx)] == $past(wr_limit)
                          && tbl_perm[$past(wr_idx)] == $past(wr_perm));

    // R9
    user_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_priv |=> tbl_base[$past(wr_idx)] == $past(tbl_base[wr_idx])
                           && tbl_limit[$past(wr_idx)] == $past(tbl_limit[wr_idx])
                           && tbl_perm[$past(wr_idx)] == $past(tbl_perm[wr_idx]));
endmodule

// File: rtl/seg_check.sv
// Module: combinational bounds and permission check plus relocation.
// Takes one looked-up descriptor and the offset. Returns a fault code, and
// base plus offset when no fault is found. Bounds takes priority over permission.
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W  = 28,
    parameter int PA_W   = 32
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        acc,
    input  logic [PA_W-1:0]   base,
    input  logic [OFF_W-1:0]  limit,
    input  logic [PERM_W-1:0] perm,
    output logic [1:0]        fault,
    output logic [PA_W-1:0]   paddr
);
    logic over;
    logic allowed;

    // Bounds test: the limit is the highest legal offset.
    assign over = off > limit;

    // Permission test: pick the bit that matches the access kind.
    always_comb begin
        case (acc)
            ACC_READ:  allowed = perm[PERM_RD];
            ACC_WRITE: allowed = perm[PERM_WR];
            ACC_FETCH: allowed = perm[PERM_EX];
            default:   allowed = 1'b0;
        endcase
    end

    // Fault priority and relocated address.
    always_comb begin
        if (over) begin
            fault = FLT_BOUNDS;
            paddr = '0;
        end else if (!allowed) begin
            fault = FLT_PERM;
            paddr = '0;
        end else begin
            fault = FLT_NONE;
            paddr = base + PA_W'(off);
        end
    end

    // R6
    fault_onehot_chk: assert final ($onehot0(fault));
endmodule

// File: rtl/seg_rsp_reg.sv
// Module: the single output register stage.
// Captures the checker's result whenever a request is present. Drives zeros
// in a cycle that has no request. Assumes synchronous active-low reset.
module seg_rsp_reg #(
    parameter int PA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      in_fault,
    input  logic [PA_W-1:0] in_paddr,
    output logic            rsp_valid,
    output logic [1:0]      rsp_fault,
    output logic [PA_W-1:0] rsp_paddr
);
    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= '0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= in_valid;
            rsp_fault <= in_valid ? in_fault : 2'b00;
            rsp_paddr <= in_valid ? in_paddr : '0;
        end
    end

    // R7
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> rsp_valid);
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !rsp_valid && rsp_fault == 2'b00 && rsp_paddr == '0);
endmodule

// File: rtl/seg_xlate.sv
// Module: top of the segment table translator.
// Splits the virtual address into a segment number and an offset, looks up the
// descriptor, checks it, and registers the result. Assumes VA_W > SEG_W and
// that the offset is no wider than the physical address.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int SEG_W = 4,
    parameter int PA_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic [1:0]             req_acc,
    input  logic                   wr_en,
    input  logic                   wr_priv,
    input  logic [SEG_W-1:0]       wr_idx,
    input  logic [PA_W-1:0]        wr_base,
    input  logic [VA_W-SEG_W-1:0]  wr_limit,
    input  logic [2:0]             wr_perm,
    input  logic [SEG_W-1:0]       rd_idx,
    output logic [PA_W-1:0]        rd_base,
    output logic [VA_W-SEG_W-1:0]  rd_limit,
    output logic [2:0]             rd_perm,
    output logic                   rsp_valid,
    output logic [PA_W-1:0]        rsp_paddr,
    output logic [1:0]             rsp_fault
);
    localparam int OFF_W = VA_W - SEG_W;

    logic [SEG_W-1:0]  seg_no;
    logic [OFF_W-1:0]  seg_off;
    logic [PA_W-1:0]   lk_base;
    logic [OFF_W-1:0]  lk_limit;
    logic [PERM_W-1:0] lk_perm;
    logic [1:0]        chk_fault;
    logic [PA_W-1:0]   chk_paddr;

    // R2: address split into segment number and offset.
    assign seg_no  = req_vaddr[VA_W-1 -: SEG_W];
    assign seg_off = req_vaddr[OFF_W-1:0];

    seg_desc_table #(
        .SEG_W(SEG_W), .BASE_W(PA_W), .LIM_W(OFF_W), .PERM_W(PERM_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_priv(wr_priv), .wr_idx(wr_idx),
        .wr_base(wr_base), .wr_limit(wr_limit), .wr_perm(wr_perm),
        .lk_idx(seg_no), .lk_base(lk_base), .lk_limit(lk_limit), .lk_perm(lk_perm),
        .rd_idx(rd_idx), .rd_base(rd_base), .rd_limit(rd_limit), .rd_perm(rd_perm)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .off(seg_off), .acc(req_acc), .base(lk_base), .limit(lk_limit),
        .perm(lk_perm), .fault(chk_fault), .paddr(chk_paddr)
    );

    seg_rsp_reg #(.PA_W(PA_W)) u_rsp (
        .clk(clk), .rst_n(rst_n),
        .in_valid(req_valid), .in_fault(chk_fault), .in_paddr(chk_paddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    // R3
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 2'b00 |-> rsp_paddr == '0);
    // R5
    reserved_acc_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_acc == 2'b11 |=> rsp_fault != 2'b00);
    // R6
    fault_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_fault));
endmodule

// File: tb/seg_xlate_test.sv
// Bench: behavioural reference model of the translator, compared every cycle.
module seg_xlate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        wr_en = 1'b0;
    logic        wr_priv = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_base = '0;
    logic [27:0] wr_limit = '0;
    logic [2:0]  wr_perm = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_base;
    logic [27:0] rd_limit;
    logic [2:0]  rd_perm;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;

    // Reference model state.
    longint m_base [16];
    longint m_limit[16];
    int     m_perm [16];
    bit     e_valid = 1'b0;
    int     e_fault = 0;
    longint e_paddr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .wr_en(wr_en), .wr_priv(wr_priv), .wr_idx(wr_idx),
        .wr_base(wr_base), .wr_limit(wr_limit), .wr_perm(wr_perm),
        .rd_idx(rd_idx), .rd_base(rd_base), .rd_limit(rd_limit), .rd_perm(rd_perm),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    // Model step at each edge: answer the request from the old table, then write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_base[i] = 0; m_limit[i] = 0; m_perm[i] = 0;
            end
            e_valid = 0; e_fault = 0; e_paddr = 0;
        end else begin
            int s; longint o; bit ok;
            e_valid = req_valid; e_fault = 0; e_paddr = 0;
            if (req_valid) begin
                s = int'(req_vaddr / 32'h1000_0000);
                o = longint'(req_vaddr % 32'h1000_0000);
                case (req_acc)
                    2'd0: ok = (m_perm[s] % 2) == 1;
                    2'd1: ok = ((m_perm[s] / 2) % 2) == 1;
                    2'd2: ok = ((m_perm[s] / 4) % 2) == 1;
                    default: ok = 0;
                endcase
                if (o > m_limit[s])   e_fault = 1;
                else if (!ok)         e_fault = 2;
                else                  e_paddr = (m_base[s] + o) % 64'h1_0000_0000;
            end
            if (wr_en && wr_priv) begin
                m_base[wr_idx] = longint'(wr_base);
                m_limit[wr_idx] = longint'(wr_limit);
                m_perm[wr_idx] = int'(wr_perm);
            end
        end
    end

    // Compare the response on every falling edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            string tag;
            if (!e_valid)          tag = "R7";
            else if (e_fault == 1) tag = "R3";
            else if (e_fault == 2) tag = "R5";
            else                   tag = "R4";
            checks++;
            if (rsp_valid !== e_valid || int'(rsp_fault) !== e_fault
                || longint'(rsp_paddr) !== e_paddr) begin
                fails++;
                $display("FAIL %s: got v=%0b f=%0d pa=%h, expected v=%0b f=%0d pa=%h",
                         tag, rsp_valid, rsp_fault, rsp_paddr, e_valid, e_fault, e_paddr);
            end
        end
    end

    task automatic check_rb(input int idx, input string tag);
        rd_idx = 4'(idx);
        #1;
        checks++;
        if (longint'(rd_base) !== m_base[idx] || longint'(rd_limit) !== m_limit[idx]
            || int'(rd_perm) !== m_perm[idx]) begin
            fails++;
            $display("FAIL %s: entry %0d got %h/%h/%0d, expected %h/%h/%0d", tag, idx,
                     rd_base, rd_limit, rd_perm, m_base[idx], m_limit[idx], m_perm[idx]);
        end
    endtask

    // Drive one cycle of inputs at a falling edge.
    task automatic cyc(input bit rv, input logic [31:0] va, input logic [1:0] acc,
                       input bit we, input bit pr, input int idx,
                       input logic [31:0] b, input logic [27:0] l, input logic [2:0] p);
        @(negedge clk);
        req_valid = rv; req_vaddr = va; req_acc = acc;
        wr_en = we; wr_priv = pr; wr_idx = 4'(idx);
        wr_base = b; wr_limit = l; wr_perm = p;
    endtask

    task automatic req(input logic [31:0] va, input logic [1:0] acc);
        cyc(1, va, acc, 0, 0, 0, '0, '0, '0);
    endtask

    task automatic wr(input int idx, input logic [31:0] b, input logic [27:0] l,
                      input logic [2:0] p, input bit pr);
        cyc(0, '0, 2'd0, 1, pr, idx, b, l, p);
    endtask

    task automatic idle();
        cyc(0, '0, 2'd0, 0, 0, 0, '0, '0, '0);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_up();
    end

    initial begin
        // R1: reset clears the table and the response.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_on = 1'b1;
        for (int i = 0; i < 16; i++) check_rb(i, "R1");
        rst_n = 1'b1;
        // R5/R6 on an empty entry: offset 0 hits a permission fault, offset 1 both.
        req(32'h0000_0000, 2'd0);
        req(32'h0000_0001, 2'd0);
        // R8: a privileged write; a request in the same cycle sees the old entry.
        cyc(1, 32'h3000_0000, 2'd0, 1, 1, 3, 32'h8000_0000, 28'h0000FFF, 3'b011);
        req(32'h3000_0FFF, 2'd0);   // R3 boundary: equal to the limit is legal
        req(32'h3000_1000, 2'd0);   // R3: one past the limit
        req(32'h3000_0010, 2'd2);   // R5: fetch not allowed
        req(32'h3000_0010, 2'd1);   // R4: write allowed
        req(32'h3000_0010, 2'd3);   // R5: reserved kind
        req(32'h3000_2000, 2'd2);   // R6: both fail, bounds wins
        // R9: an unprivileged write changes nothing.
        wr(3, 32'h1234_5000, 28'hFFF_FFFF, 3'b111, 0);
        idle();
        check_rb(3, "R9");
        req(32'h3000_5000, 2'd0);
        // R4: the sum wraps modulo 2^32.
        wr(15, 32'hFFFF_F000, 28'hFFF_FFFF, 3'b111, 1);
        req(32'hF000_2000, 2'd2);
        req(32'hFFFF_FFFF, 2'd0);
        idle();
        // R11: fill every entry, then back-to-back mixed traffic.
        for (int i = 0; i < 16; i++)
            wr(i, $urandom, 28'($urandom % 28'h0100_0000), 3'($urandom), 1);
        for (int i = 0; i < 16; i++) check_rb(i, "R10");
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom % 8);
            logic [31:0] va = $urandom;
            if (r == 0) va[27:0] = 28'($urandom % 28'h0200_0000);
            cyc(r != 7, va, 2'($urandom), r >= 5, r == 6,
                int'($urandom % 16), $urandom, 28'($urandom % 28'h0200_0000), 3'($urandom));
        end
        idle();
        idle();
        for (int i = 0; i < 16; i++) check_rb(i, "R8");
        // R1 again: a mid-run reset clears the table.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_rb(7, "R1");
        rst_n = 1'b1;
        idle();
        idle();
        finish_up();
    end
endmodule